// File: doc/BRIEF.md
# Keyboard and Mouse Wake and Isolation Controller

This block sits between the two PS/2-style device ports (clock and data for a keyboard and for a mouse) and the internal keyboard controller. It watches for four kinds of activity: an interrupt from the controller for each device, and a falling edge on each device's data line. Each kind of activity sets a sticky status bit. A wake request is raised when a pending status bit is enabled for wake and the global wake enable is on. Interrupt events count only while main power is present. Data-line events also count on standby power alone.

Before sleep, the block can cut the clock and data paths into the controller, either under hardware control (the power-down indication) or under software control, as chosen by a mode bit. A blocked path is driven to the idle high level. The wake detectors always see the raw pins. The interrupt outputs can either pass a latched copy of the controller interrupt or the live interrupt ANDed with that copy.

Top module: `kbm_wake_iso`

## Requirements
- R1: Status bit 0 is set by a rising edge on the keyboard interrupt input, and bit 1 by a rising edge on the mouse interrupt input. Each is set one clock after the rising edge, and only while `main_pwr` is 1.
- R2: Status bit 2 is set by a falling edge on the keyboard data pin, and bit 3 by a falling edge on the mouse data pin, whatever the value of `main_pwr`. Each pin passes through a two-flop synchronizer, so the status bit is set on the third clock edge after the pin falls.
- R3: Writing a 1 to a status bit through `sts_clr_we`/`sts_clr_mask` clears it. A new event in the same cycle as the clear leaves the bit set.
- R4: `wake_req` is 1 exactly when `wake_glob_en` is 1 and at least one status bit is set whose matching `wake_en` bit is also set.
- R5: The control register is written through `ctrl_we` and read on `ctrl_rdata`. Bit 5 blocks the keyboard clock and data paths into the controller, and bit 6 blocks the mouse paths. With bit 7 at 0, `pwr_down` also blocks all four paths. A blocked path reads 1. An unblocked path follows its pin.
- R6: With control bit 7 at 1, the clock paths are blocked by the software bits only. The data paths into the controller are still blocked while `pwr_down` is 1.
- R7: Isolation never hides a data-pin edge from the wake detectors.
- R8: When control bit 3 (keyboard) or bit 4 (mouse) is 0, the interrupt output is the live interrupt ANDed with its latched copy. When the bit is 1, the output is the latched copy. The latched copy is set on a rising edge of the live interrupt and cleared by a write-1 clear of the matching status bit.
- R9: Control bits 7..5 are reset only by `stby_por_n`. Bits 4..3 are also reset by `main_rst_n`. Bits 2..0 read as 0. All control bits reset to 0.
- R10: After the standby power-on reset, all status bits are 0, `wake_req` is 0, the interrupt outputs are 0, and every controller path follows its pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| stby_por_n | input | 1 | Standby-power power-on reset, active low, asynchronous |
| main_rst_n | input | 1 | Main-power reset, active low, asynchronous |
| main_pwr | input | 1 | Main power present |
| pwr_down | input | 1 | Power-down indication, active high |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 5 | Control write data, bits 7..3 |
| ctrl_rdata | output | 8 | Control register readback |
| sts_clr_we | input | 1 | Status clear strobe |
| sts_clr_mask | input | 4 | Write-1-to-clear mask for the status bits |
| sts_o | output | 4 | Sticky status: 0 kbd int, 1 mouse int, 2 kbd data edge, 3 mouse data edge |
| wake_en | input | 4 | Per-event wake enables |
| wake_glob_en | input | 1 | Global wake enable |
| wake_req | output | 1 | Wake request |
| kb_clk_pin | input | 1 | Keyboard clock pin |
| kb_dat_pin | input | 1 | Keyboard data pin |
| ms_clk_pin | input | 1 | Mouse clock pin |
| ms_dat_pin | input | 1 | Mouse data pin |
| kbc_kclk | output | 1 | Keyboard clock into the controller |
| kbc_kdat | output | 1 | Keyboard data into the controller |
| kbc_mclk | output | 1 | Mouse clock into the controller |
| kbc_mdat | output | 1 | Mouse data into the controller |
| kbc_kint | input | 1 | Keyboard interrupt from the controller |
| kbc_mint | input | 1 | Mouse interrupt from the controller |
| kint_out | output | 1 | Keyboard interrupt output |
| mint_out | output | 1 | Mouse interrupt output |

## Verification
The checker tests several rules on every cycle:
- a status bit stays set until it is cleared;
- a keyboard-interrupt status bit rises only after a cycle with main power present;
- `wake_req` stays low without the global enable or without pending status;
- the software isolation bits and power-down force the controller paths high;
- clock paths in the software-only mode follow the pin;
- the AND-combined interrupt output is never high while the live interrupt is low;
- the isolation bits change only on a register write.

Only the directed scenarios can show the rest: the exact synchronizer latency, set-over-clear priority, the hold of the latched interrupt until a status clear, the split between the two reset domains, and an edge reaching the wake logic while its path into the controller is blocked.

// File: rtl/kbm_pkg.sv
package kbm_pkg;
    localparam int N_DEV    = 2;  // index 0 keyboard, 1 mouse
    localparam int N_EVT    = 4;
    localparam int EVT_KINT = 0;
    localparam int EVT_MINT = 1;
    localparam int EVT_KDAT = 2;
    localparam int EVT_MDAT = 3;

    localparam int B_MODE = 7;
    localparam int B_MISO = 6;
    localparam int B_KISO = 5;
    localparam int B_MLAT = 4;
    localparam int B_KLAT = 3;

    // standby-domain configuration
    typedef struct packed {
        logic mode;
        logic m_iso;
        logic k_iso;
    } iso_cfg_t;

    // main-domain configuration
    typedef struct packed {
        logic m_lat;
        logic k_lat;
    } lat_cfg_t;
endpackage

// File: rtl/kbm_fall_det.sv
module kbm_fall_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              last;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], pin};
        st_d.last = st_q.sync[STAGES-1];
        fall      = st_q.last & ~st_q.sync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;   // idle-high line
        else        st_q <= st_d;
    end
endmodule

// File: rtl/kbm_int_latch.sv
module kbm_int_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic live,
    input  logic clr,
    input  logic pass_latched,
    output logic rise,
    output logic int_o
);
    typedef struct packed {
        logic prev;
        logic lat;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        rise      = live & ~st_q.prev;
        st_d.prev = live;
        if (rise)     st_d.lat = 1'b1;
        else if (clr) st_d.lat = 1'b0;
        int_o = pass_latched ? st_q.lat : (live & st_q.lat);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/kbm_iso_gate.sv
module kbm_iso_gate (
    input  logic sw_only,
    input  logic sw_iso,
    input  logic pwr_down,
    input  logic pin_clk,
    input  logic pin_dat,
    output logic out_clk,
    output logic out_dat
);
    logic blk_clk, blk_dat;

    always_comb begin
        blk_clk = sw_iso | (pwr_down & ~sw_only);
        // the data input path is cut during power-down in either mode
        blk_dat = sw_iso | pwr_down;
        out_clk = blk_clk | pin_clk;
        out_dat = blk_dat | pin_dat;
    end
endmodule

// File: rtl/kbm_wake_iso.sv
module kbm_wake_iso
    import kbm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       stby_por_n,
    input  logic       main_rst_n,
    input  logic       main_pwr,
    input  logic       pwr_down,
    input  logic       ctrl_we,
    input  logic [7:3] ctrl_wdata,
    output logic [7:0] ctrl_rdata,
    input  logic       sts_clr_we,
    input  logic [3:0] sts_clr_mask,
    output logic [3:0] sts_o,
    input  logic [3:0] wake_en,
    input  logic       wake_glob_en,
    output logic       wake_req,
    input  logic       kb_clk_pin,
    input  logic       kb_dat_pin,
    input  logic       ms_clk_pin,
    input  logic       ms_dat_pin,
    output logic       kbc_kclk,
    output logic       kbc_kdat,
    output logic       kbc_mclk,
    output logic       kbc_mdat,
    input  logic       kbc_kint,
    input  logic       kbc_mint,
    output logic       kint_out,
    output logic       mint_out
);
    localparam logic [N_EVT-1:0] NO_EVT = '0;

    typedef struct packed {
        iso_cfg_t         iso;
        logic [N_EVT-1:0] sts;
    } stby_t;

    typedef struct packed {
        lat_cfg_t lat;
    } main_t;

    stby_t sb_d, sb_q;
    main_t mn_d, mn_q;

    logic main_dom_rst_n;
    assign main_dom_rst_n = stby_por_n & main_rst_n;

    logic [N_DEV-1:0] pin_clk, pin_dat, live_int, sw_iso, lat_sel;
    logic [N_DEV-1:0] fall, rise, int_o, out_clk, out_dat;
    logic [N_EVT-1:0] clr, set;

    assign pin_clk  = {ms_clk_pin, kb_clk_pin};
    assign pin_dat  = {ms_dat_pin, kb_dat_pin};
    assign live_int = {kbc_mint, kbc_kint};
    assign sw_iso   = {sb_q.iso.m_iso, sb_q.iso.k_iso};
    assign lat_sel  = {mn_q.lat.m_lat, mn_q.lat.k_lat};

    for (genvar i = 0; i < N_DEV; i++) begin : g_dev
        kbm_fall_det #(.STAGES(SYNC_STAGES)) i_fall (
            .clk   (clk),
            .rst_n (stby_por_n),
            .pin   (pin_dat[i]),
            .fall  (fall[i])
        );

        kbm_int_latch i_lat (
            .clk          (clk),
            .rst_n        (main_dom_rst_n),
            .live         (live_int[i]),
            .clr          (clr[EVT_KINT + i]),
            .pass_latched (lat_sel[i]),
            .rise         (rise[i]),
            .int_o        (int_o[i])
        );

        kbm_iso_gate i_gate (
            .sw_only  (sb_q.iso.mode),
            .sw_iso   (sw_iso[i]),
            .pwr_down (pwr_down),
            .pin_clk  (pin_clk[i]),
            .pin_dat  (pin_dat[i]),
            .out_clk  (out_clk[i]),
            .out_dat  (out_dat[i])
        );
    end

    always_comb begin
        sb_d = sb_q;
        mn_d = mn_q;

        clr = sts_clr_we ? sts_clr_mask : NO_EVT;
        set = NO_EVT;
        set[EVT_KINT] = rise[0] & main_pwr;
        set[EVT_MINT] = rise[1] & main_pwr;
        set[EVT_KDAT] = fall[0];
        set[EVT_MDAT] = fall[1];

        // a new event wins over a clear in the same cycle
        sb_d.sts = (sb_q.sts & ~clr) | set;

        if (ctrl_we) begin
            sb_d.iso.mode  = ctrl_wdata[B_MODE];
            sb_d.iso.m_iso = ctrl_wdata[B_MISO];
            sb_d.iso.k_iso = ctrl_wdata[B_KISO];
            mn_d.lat.m_lat = ctrl_wdata[B_MLAT];
            mn_d.lat.k_lat = ctrl_wdata[B_KLAT];
        end
    end

    always_ff @(posedge clk or negedge stby_por_n) begin
        if (!stby_por_n) sb_q <= '0;
        else             sb_q <= sb_d;
    end

    always_ff @(posedge clk or negedge main_dom_rst_n) begin
        if (!main_dom_rst_n) mn_q <= '0;
        else                 mn_q <= mn_d;
    end

    always_comb begin
        ctrl_rdata         = '0;
        ctrl_rdata[B_MODE] = sb_q.iso.mode;
        ctrl_rdata[B_MISO] = sb_q.iso.m_iso;
        ctrl_rdata[B_KISO] = sb_q.iso.k_iso;
        ctrl_rdata[B_MLAT] = mn_q.lat.m_lat;
        ctrl_rdata[B_KLAT] = mn_q.lat.k_lat;
    end

    assign sts_o    = sb_q.sts;
    assign wake_req = wake_glob_en & (|(sb_q.sts & wake_en));
    assign kbc_kclk = out_clk[0];
    assign kbc_kdat = out_dat[0];
    assign kbc_mclk = out_clk[1];
    assign kbc_mdat = out_dat[1];
    assign kint_out = int_o[0];
    assign mint_out = int_o[1];
endmodule

// File: rtl/kbm_wake_iso_chk.sv
module kbm_wake_iso_chk (
    input logic       clk,
    input logic       stby_por_n,
    input logic       main_pwr,
    input logic       pwr_down,
    input logic       ctrl_we,
    input logic [7:0] ctrl_rdata,
    input logic       sts_clr_we,
    input logic [3:0] sts_clr_mask,
    input logic [3:0] sts_o,
    input logic       wake_glob_en,
    input logic       wake_req,
    input logic       kb_clk_pin,
    input logic       kbc_kclk,
    input logic       kbc_kdat,
    input logic       kbc_mclk,
    input logic       kbc_mdat,
    input logic       kbc_kint,
    input logic       kint_out
);
    logic [3:0] keep;
    assign keep = sts_o & ~(sts_clr_we ? sts_clr_mask : 4'h0);

    // R1
    kint_pwr_gate_chk: assert property (@(posedge clk) disable iff (!stby_por_n)
        $rose(sts_o[0]) |-> $past(main_pwr));

    // R3
    sts_sticky_chk: assert property (@(posedge clk) disable iff (!stby_por_n)
        (keep != 4'h0) |=> ((sts_o & $past(keep)) == $past(keep)));

    // R4
    wake_glob_chk: assert property (@(posedge clk) disable iff (!stby_por_n)
        !wake_glob_en |-> !wake_req);

    // R4
    wake_idle_chk: assert property (@(posedge clk) disable iff (!stby_por_n)
        (sts_o == 4'h0) |-> !wake_req);

    // R5
    kbd_iso_chk: assert property (@(posedge clk) disable iff (!stby_por_n)
        ctrl_rdata[5] |-> (kbc_kclk && kbc_kdat));

    // R5
    ms_iso_chk: assert property (@(posedge clk) disable iff (!stby_por_n)
        ctrl_rdata[6] |-> (kbc_mclk && kbc_mdat));

    // R6
    sw_only_clk_chk: assert property (@(posedge clk) disable iff (!stby_por_n)
        (ctrl_rdata[7] && !ctrl_rdata[5]) |-> (kbc_kclk == kb_clk_pin));

    // R6
    pd_dat_chk: assert property (@(posedge clk) disable iff (!stby_por_n)
        pwr_down |-> (kbc_kdat && kbc_mdat));

    // R8
    kint_and_chk: assert property (@(posedge clk) disable iff (!stby_por_n)
        (!ctrl_rdata[3] && !kbc_kint) |-> !kint_out);

    // R9
    iso_hold_chk: assert property (@(posedge clk) disable iff (!stby_por_n)
        !ctrl_we |=> $stable(ctrl_rdata[7:5]));

    // R9
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!stby_por_n)
        ctrl_rdata[2:0] == 3'b000);
endmodule

bind kbm_wake_iso kbm_wake_iso_chk i_chk (.*);

// File: tb/test_kbm_wake_iso.sv
module test_kbm_wake_iso;
    logic       clk = 1'b0;
    logic       stby_por_n, main_rst_n, main_pwr, pwr_down;
    logic       ctrl_we;
    logic [7:3] ctrl_wdata;
    logic [7:0] ctrl_rdata;
    logic       sts_clr_we;
    logic [3:0] sts_clr_mask, sts_o, wake_en;
    logic       wake_glob_en, wake_req;
    logic       kb_clk_pin, kb_dat_pin, ms_clk_pin, ms_dat_pin;
    logic       kbc_kclk, kbc_kdat, kbc_mclk, kbc_mdat;
    logic       kbc_kint, kbc_mint, kint_out, mint_out;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    kbm_wake_iso i_kbm_wake_iso (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(logic [7:0] v);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v[7:3];
        @(negedge clk); ctrl_we = 1'b0;
    endtask

    task automatic clr_sts(logic [3:0] m);
        @(negedge clk); sts_clr_we = 1'b1; sts_clr_mask = m;
        @(negedge clk); sts_clr_we = 1'b0;
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        settle(1);
        chk("R10 ctrl after por", ctrl_rdata, 8'h00);
        chk("R10 status after por", sts_o, 4'h0);
        chk("R10 wake after por", wake_req, 1'b0);
        chk("R10 paths follow pins", {kbc_kclk, kbc_kdat, kbc_mclk, kbc_mdat}, 4'hF);
        chk("R10 int outputs", {kint_out, mint_out}, 2'b00);
    endtask

    task automatic t_events;
        // R1: interrupt edge with main power present
        @(negedge clk); kbc_kint = 1'b1;
        @(negedge clk); chk("R1 kbd int sets bit0", sts_o, 4'h1); kbc_kint = 1'b0;
        clr_sts(4'hF);
        // R1: no event without main power
        main_pwr = 1'b0;
        @(negedge clk); kbc_kint = 1'b1;
        @(negedge clk); kbc_kint = 1'b0;
        settle(1);
        chk("R1 kbd int ignored off main power", sts_o, 4'h0);
        main_pwr = 1'b1;
        @(negedge clk); kbc_mint = 1'b1;
        @(negedge clk); chk("R1 mouse int sets bit1", sts_o, 4'h2); kbc_mint = 1'b0;
        clr_sts(4'hF);
        // R2: data edge on standby power alone, latency of three edges
        main_pwr = 1'b0;
        @(negedge clk); kb_dat_pin = 1'b0;
        settle(2);
        chk("R2 no status before sync delay", sts_o, 4'h0);
        settle(1);
        chk("R2 kbd data edge sets bit2", sts_o, 4'h4);
        kb_dat_pin = 1'b1;
        settle(4);
        chk("R2 rising edge ignored", sts_o, 4'h4);
        main_pwr = 1'b1;
        clr_sts(4'hF);
        chk("R3 clear all", sts_o, 4'h0);
    endtask

    task automatic t_set_wins;
        @(negedge clk); kbc_kint = 1'b1;
        @(negedge clk); kbc_kint = 1'b0;
        settle(1);
        @(negedge clk); kbc_kint = 1'b1; sts_clr_we = 1'b1; sts_clr_mask = 4'h1;
        @(negedge clk); kbc_kint = 1'b0; sts_clr_we = 1'b0;
        chk("R3 set wins over clear", sts_o[0], 1'b1);
        clr_sts(4'h1);
        chk("R3 write-1 clears", sts_o, 4'h0);
    endtask

    task automatic t_latch;
        wr_ctrl(8'h00);
        @(negedge clk); kbc_kint = 1'b1;
        @(negedge clk); chk("R8 and mode high", kint_out, 1'b1);
        kbc_kint = 1'b0; #1;
        chk("R8 and mode follows live low", kint_out, 1'b0);
        wr_ctrl(8'h08);
        chk("R8 latched mode holds", kint_out, 1'b1);
        clr_sts(4'h1);
        chk("R8 status clear drops latch", kint_out, 1'b0);
        @(negedge clk); kbc_mint = 1'b1;
        @(negedge clk); kbc_mint = 1'b0;
        settle(1);
        chk("R8 mouse and mode low", mint_out, 1'b0);
        wr_ctrl(8'h10);
        chk("R8 mouse latched mode", mint_out, 1'b1);
        clr_sts(4'hF);
        wr_ctrl(8'h00);
    endtask

    task automatic t_iso;
        @(negedge clk);
        {kb_clk_pin, kb_dat_pin, ms_clk_pin, ms_dat_pin} = 4'h0; #1;
        chk("R5 pass through", {kbc_kclk, kbc_kdat, kbc_mclk, kbc_mdat}, 4'h0);
        pwr_down = 1'b1; #1;
        chk("R5 power-down blocks all", {kbc_kclk, kbc_kdat, kbc_mclk, kbc_mdat}, 4'hF);
        pwr_down = 1'b0;
        wr_ctrl(8'h20);
        chk("R5 kbd sw block", {kbc_kclk, kbc_kdat, kbc_mclk, kbc_mdat}, 4'hC);
        wr_ctrl(8'h40);
        chk("R5 mouse sw block", {kbc_kclk, kbc_kdat, kbc_mclk, kbc_mdat}, 4'h3);
        wr_ctrl(8'h80);
        pwr_down = 1'b1; #1;
        chk("R6 sw-only mode with power-down", {kbc_kclk, kbc_kdat, kbc_mclk, kbc_mdat}, 4'h5);
        wr_ctrl(8'hA0);
        chk("R6 sw-only mode kbd bit", {kbc_kclk, kbc_kdat, kbc_mclk, kbc_mdat}, 4'hD);
        pwr_down = 1'b0;
        wr_ctrl(8'h00);
        {kb_clk_pin, kb_dat_pin, ms_clk_pin, ms_dat_pin} = 4'hF;
        settle(4);
        clr_sts(4'hF);
    endtask

    task automatic t_iso_wake;
        wr_ctrl(8'h60);
        @(negedge clk); ms_dat_pin = 1'b0; #1;
        chk("R7 blocked path reads high", kbc_mdat, 1'b1);
        settle(4);
        chk("R7 wake sees blocked edge", sts_o, 4'h8);
        ms_dat_pin = 1'b1;
        settle(4);
        wake_en = 4'h8; wake_glob_en = 1'b0; #1;
        chk("R4 no wake without global", wake_req, 1'b0);
        wake_glob_en = 1'b1; #1;
        chk("R4 wake asserted", wake_req, 1'b1);
        wake_en = 4'h1; #1;
        chk("R4 disabled event no wake", wake_req, 1'b0);
        wake_glob_en = 1'b0; wake_en = 4'h0;
        clr_sts(4'hF);
        wr_ctrl(8'h00);
    endtask

    task automatic t_resets;
        wr_ctrl(8'hF8);
        chk("R9 readback", ctrl_rdata, 8'hF8);
        @(negedge clk); main_rst_n = 1'b0;
        @(negedge clk); main_rst_n = 1'b1;
        chk("R9 main reset keeps isolation bits", ctrl_rdata, 8'hE0);
        @(negedge clk); stby_por_n = 1'b0;
        @(negedge clk); stby_por_n = 1'b1;
        chk("R9 standby reset clears all", ctrl_rdata, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        stby_por_n = 1'b0; main_rst_n = 1'b0; main_pwr = 1'b1; pwr_down = 1'b0;
        ctrl_we = 1'b0; ctrl_wdata = '0; sts_clr_we = 1'b0; sts_clr_mask = '0;
        wake_en = '0; wake_glob_en = 1'b0;
        {kb_clk_pin, kb_dat_pin, ms_clk_pin, ms_dat_pin} = 4'hF;
        kbc_kint = 1'b0; kbc_mint = 1'b0;
        settle(3);
        stby_por_n = 1'b1; main_rst_n = 1'b1;
        t_reset;
        t_events;
        t_set_wins;
        t_latch;
        t_iso;
        t_iso_wake;
        t_resets;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule